// File: doc/BRIEF.md
# Single-Line Test Boundary (Device Side)

This block sits inside a device under test and connects one shared, direction-switched test line to the device's parallel stimulus and response pins. A hub at the other end of the line first sends a start bit and then a fixed number of pattern bits. The block assembles these bits into a test word and presents the whole word on its test pins at once. On the next clock it samples the device's response pins. It then drives that response word back over the same line, one bit per clock, while its output enable is asserted.

A sequencing counter counts the received bits and the returned bits. When the last response bit has left, the block raises a completion flag and releases the line. The bit counts are parameters and must equal the lengths the hub uses for its transmit and receive windows. The block has no identification, instruction or bypass register. The pad driver is outside the block: it takes `line_out` and `line_oe` and returns the line level on `line_in`.

Top module: `sl_test_boundary`

## Requirements
- R1: A synchronous `test_rst` clears `test_pins` to 0, deasserts `line_oe` and `resp_done`, and returns the block to idle.
- R2: A transaction starts only when the block is idle or done, `dev_sel` is 1 and `line_in` is 1 at a rising clock edge (the start bit). A low line while idle starts nothing.
- R3: The TEST_W clocks that follow the start bit each carry one pattern bit on `line_in`. The first bit received lands in `test_pins[0]` and the last in `test_pins[TEST_W-1]`.
- R4: `test_pins` changes only at the edge that samples the last pattern bit. During shifting the pins keep their previous word.
- R5: `resp_pins` is sampled exactly once, at the clock edge after the test word is applied. Later changes on `resp_pins` do not alter the bits returned.
- R6: For the RESP_W clocks after the capture, `line_oe` is 1 and `line_out` carries the captured response, least-significant bit first, one bit per clock.
- R7: After the last response bit, `resp_done` is 1 and `line_oe` is 0. Both stay that way until a new start bit, deselection or reset.
- R8: `line_oe` is 1 only while `dev_sel` is 1. Dropping `dev_sel` aborts any transaction to idle and clears `resp_done`. The line is ignored while unselected, and `test_pins` keeps its value.
- R9: A start bit received while done begins a new transaction and clears `resp_done` on that edge.
- R10: A test reset during the response phase releases the line immediately at the next edge and clears the test word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| test_rst | input | 1 | Synchronous active-high test reset |
| dev_sel | input | 1 | Device selected by the hub |
| line_in | input | 1 | Level received from the shared test line |
| line_out | output | 1 | Response bit to drive onto the line |
| line_oe | output | 1 | Line driver enable (0 means high impedance) |
| test_pins | output | TEST_W | Parallel stimulus word to the core |
| resp_pins | input | RESP_W | Parallel response word from the core |
| resp_done | output | 1 | Response fully returned |

## Verification
On every cycle, the assertions check four things. The driver is never enabled without selection or while the done flag is up. The stimulus pins hold steady outside the shifting phase. A start bit always enters the receive phase, and reset always leaves the line released with a cleared word. Only the bench's scenarios can show that the bits land in the right order and that the response is sampled in the right cycle rather than later. They also show the return sequence, and that aborts by deselection or mid-response reset leave the block ready for a clean new transaction.

// File: rtl/sl_test_pkg.sv
package sl_test_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RX   = 3'd1,
        PH_CAP  = 3'd2,
        PH_TX   = 3'd3,
        PH_DONE = 3'd4
    } phase_e;
endpackage

// File: rtl/sl_seq_ctrl.sv
module sl_seq_ctrl
    import sl_test_pkg::*;
#(
    parameter int TEST_W = 8,
    parameter int RESP_W = 5
) (
    input  logic   clk,
    input  logic   test_rst,
    input  logic   dev_sel,
    input  logic   line_in,
    output phase_e phase,
    output logic   shift_en,
    output logic   apply_en,
    output logic   capture_en,
    output logic   tx_shift,
    output logic   tx_en
);
    localparam int MAXW = (TEST_W > RESP_W) ? TEST_W : RESP_W;
    localparam int CW   = $clog2(MAXW + 1);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        shift_en   = 1'b0;
        apply_en   = 1'b0;
        capture_en = 1'b0;
        tx_shift   = 1'b0;
        if (!dev_sel) begin
            ctl_d.ph  = PH_IDLE;
            ctl_d.cnt = '0;
        end else begin
            unique case (ctl_q.ph)
                PH_IDLE, PH_DONE: begin
                    if (line_in) begin
                        ctl_d.ph  = PH_RX;
                        ctl_d.cnt = '0;
                    end
                end
                PH_RX: begin
                    shift_en = 1'b1;
                    if (ctl_q.cnt == CW'(TEST_W - 1)) begin
                        apply_en  = 1'b1;
                        ctl_d.ph  = PH_CAP;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                PH_CAP: begin
                    capture_en = 1'b1;
                    ctl_d.ph   = PH_TX;
                    ctl_d.cnt  = '0;
                end
                PH_TX: begin
                    tx_shift = 1'b1;
                    if (ctl_q.cnt == CW'(RESP_W - 1)) begin
                        ctl_d.ph  = PH_DONE;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                default: begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (test_rst) begin
            ctl_q.ph  <= PH_IDLE;
            ctl_q.cnt <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase = ctl_q.ph;
    assign tx_en = dev_sel && (ctl_q.ph == PH_TX);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (test_rst)
        int'(ctl_q.cnt) < MAXW);
endmodule

// File: rtl/sl_sipo.sv
module sl_sipo #(
    parameter int TEST_W = 8
) (
    input  logic              clk,
    input  logic              test_rst,
    input  logic              line_in,
    input  logic              shift_en,
    input  logic              apply_en,
    output logic [TEST_W-1:0] test_pins
);
    typedef struct packed {
        logic [TEST_W-1:0] sh;
        logic [TEST_W-1:0] pins;
    } sipo_t;

    sipo_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) s_d.sh = {line_in, s_q.sh[TEST_W-1:1]};
        if (apply_en) s_d.pins = {line_in, s_q.sh[TEST_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (test_rst) s_q <= '0;
        else          s_q <= s_d;
    end

    assign test_pins = s_q.pins;
endmodule

// File: rtl/sl_piso.sv
module sl_piso #(
    parameter int RESP_W = 5
) (
    input  logic              clk,
    input  logic              test_rst,
    input  logic [RESP_W-1:0] resp_pins,
    input  logic              capture_en,
    input  logic              tx_shift,
    output logic              tx_bit
);
    logic [RESP_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (capture_en)    sh_d = resp_pins;
        else if (tx_shift) sh_d = {1'b0, sh_q[RESP_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (test_rst) sh_q <= '0;
        else          sh_q <= sh_d;
    end

    assign tx_bit = sh_q[0];
endmodule

// File: rtl/sl_test_boundary.sv
module sl_test_boundary
    import sl_test_pkg::*;
#(
    parameter int TEST_W = 8,
    parameter int RESP_W = 5
) (
    input  logic              clk,
    input  logic              test_rst,
    input  logic              dev_sel,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_oe,
    output logic [TEST_W-1:0] test_pins,
    input  logic [RESP_W-1:0] resp_pins,
    output logic              resp_done
);
    phase_e phase;
    logic   shift_en, apply_en, capture_en, tx_shift, tx_en, tx_bit;

    sl_seq_ctrl #(.TEST_W(TEST_W), .RESP_W(RESP_W)) u_ctrl (
        .clk(clk), .test_rst(test_rst), .dev_sel(dev_sel), .line_in(line_in),
        .phase(phase), .shift_en(shift_en), .apply_en(apply_en),
        .capture_en(capture_en), .tx_shift(tx_shift), .tx_en(tx_en)
    );

    sl_sipo #(.TEST_W(TEST_W)) u_sipo (
        .clk(clk), .test_rst(test_rst), .line_in(line_in),
        .shift_en(shift_en), .apply_en(apply_en), .test_pins(test_pins)
    );

    sl_piso #(.RESP_W(RESP_W)) u_piso (
        .clk(clk), .test_rst(test_rst), .resp_pins(resp_pins),
        .capture_en(capture_en), .tx_shift(tx_shift), .tx_bit(tx_bit)
    );

    assign line_oe   = tx_en;
    assign line_out  = tx_en ? tx_bit : 1'b0;
    assign resp_done = (phase == PH_DONE);

    assert_oe_needs_sel_R8: assert property (@(posedge clk) disable iff (test_rst)
        line_oe |-> dev_sel);
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (test_rst)
        resp_done |-> !line_oe);
    assert_pins_hold_R4: assert property (@(posedge clk) disable iff (test_rst)
        (phase != PH_RX) |=> $stable(test_pins));
    assert_start_enters_rx_R2: assert property (@(posedge clk) disable iff (test_rst)
        ((phase == PH_IDLE || phase == PH_DONE) && dev_sel && line_in) |=> (phase == PH_RX));
    assert_reset_clears_R1: assert property (@(posedge clk)
        test_rst |=> (!line_oe && !resp_done && test_pins == '0));
endmodule

// File: tb/sl_test_boundary_tb.sv
module sl_test_boundary_tb_top;
    localparam int TW = 8;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          test_rst, dev_sel, line_in;
    logic          line_out, line_oe, resp_done;
    logic [TW-1:0] test_pins;
    logic [RW-1:0] resp_pins;
    int            n_chk = 0;
    int            n_bad = 0;

    always #10 clk = ~clk;

    sl_test_boundary #(.TEST_W(TW), .RESP_W(RW)) dut_i (
        .clk(clk), .test_rst(test_rst), .dev_sel(dev_sel), .line_in(line_in),
        .line_out(line_out), .line_oe(line_oe), .test_pins(test_pins),
        .resp_pins(resp_pins), .resp_done(resp_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        test_rst = 1'b1; dev_sel = 1'b0; line_in = 1'b0; resp_pins = '0;
        repeat (2) @(negedge clk);
        chk("R1 pins", 32'(test_pins), 0);
        chk("R1 oe", 32'(line_oe), 0);
        chk("R1 done", 32'(resp_done), 0);
        test_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle_low();
        dev_sel = 1'b1; line_in = 1'b0;
        repeat (TW + RW + 3) @(negedge clk);
        chk("R2 idle oe", 32'(line_oe), 0);
        chk("R2 idle done", 32'(resp_done), 0);
        chk("R2 idle pins", 32'(test_pins), 0);
    endtask

    // Full transaction; the bench is at a negedge on entry and exit.
    task automatic t_xfer(input logic [TW-1:0] tw, input logic [RW-1:0] rw, input bit from_done);
        logic [TW-1:0] prev;
        prev = test_pins;
        dev_sel = 1'b1; line_in = 1'b1; resp_pins = rw;
        @(negedge clk);
        if (from_done) chk("R9 done cleared", 32'(resp_done), 0);
        for (int i = 0; i < TW; i++) begin
            line_in = tw[i];
            if (i == TW / 2) chk("R4 pins hold", 32'(test_pins), 32'(prev));
            @(negedge clk);
        end
        line_in = 1'b0;
        chk("R3 word", 32'(test_pins), 32'(tw));
        chk("R6 oe before capture", 32'(line_oe), 0);
        @(negedge clk);
        resp_pins = ~rw;
        for (int j = 0; j < RW; j++) begin
            chk("R6 oe", 32'(line_oe), 1);
            chk("R5 R6 bit", 32'(line_out), 32'(rw[j]));
            @(negedge clk);
        end
        chk("R7 done", 32'(resp_done), 1);
        chk("R7 oe off", 32'(line_oe), 0);
        repeat (3) @(negedge clk);
        chk("R7 done held", 32'(resp_done), 1);
        chk("R3 word held", 32'(test_pins), 32'(tw));
    endtask

    task automatic t_deselect();
        logic [TW-1:0] prev;
        prev = test_pins;
        dev_sel = 1'b1; line_in = 1'b1;
        @(negedge clk);
        chk("R9 restart", 32'(resp_done), 0);
        repeat (3) @(negedge clk);
        dev_sel = 1'b0;
        @(negedge clk);
        chk("R8 oe unsel", 32'(line_oe), 0);
        line_in = 1'b1;
        repeat (TW + RW + 2) @(negedge clk);
        chk("R8 pins kept", 32'(test_pins), 32'(prev));
        chk("R8 no done", 32'(resp_done), 0);
        chk("R8 no drive", 32'(line_oe), 0);
        dev_sel = 1'b1; line_in = 1'b0;
        repeat (TW + RW + 2) @(negedge clk);
        chk("R8 still idle", 32'(resp_done), 0);
    endtask

    task automatic t_mid_reset();
        dev_sel = 1'b1; line_in = 1'b1; resp_pins = 5'h1F;
        @(negedge clk);
        for (int i = 0; i < TW; i++) begin
            line_in = 1'b1;
            @(negedge clk);
        end
        line_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 in tx", 32'(line_oe), 1);
        test_rst = 1'b1;
        @(negedge clk);
        chk("R10 oe", 32'(line_oe), 0);
        chk("R10 pins", 32'(test_pins), 0);
        chk("R10 done", 32'(resp_done), 0);
        test_rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        test_rst = 1'b1; dev_sel = 1'b0; line_in = 1'b0; resp_pins = '0;
        t_reset();
        t_idle_low();
        t_xfer(8'hA5, 5'h13, 1'b0);
        t_xfer(8'h3C, 5'h0A, 1'b1);
        t_deselect();
        t_xfer(8'hFF, 5'h1F, 1'b0);
        t_xfer(8'h01, 5'h10, 1'b1);
        t_mid_reset();
        t_xfer(8'h80, 5'h01, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule